// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one switchable logic domain up and down in a fixed order. A one-cycle request on `req_on` or `req_off` starts a sequence. The block then drives the domain's seven control bits, its SRAM power-down vector and a request to an external bus-protection sequencer. Each step that depends on the outside world waits for an acknowledge. Each such wait is bounded by a timeout counted in clock cycles.

The power switch has two stages and two acknowledges. The domain counts as on only when both acknowledges are high, and as off only when both are low. An optional SRAM isolation handshake adds a settle delay of one microsecond, counted with the `CLK_MHZ` parameter. The power-down path runs under engaged bus protection. If a wait expires during power-up, the block walks back through the steps it has already taken. It ends in the safe off state and reports an error together with done.

Top module: `pd_seq`

## Requirements
- R1: After reset, `dom_ctl` is 7'h32, `sram_pdn` is all ones, `prot_req` is 1, and `busy`, `done`, `is_on` and `err` are 0. The bits of `dom_ctl` are: bit0 active-low reset, bit1 isolation, bit2 first power switch, bit3 second power switch, bit4 clock disable, bit5 SRAM clock isolation, bit6 active-low SRAM internal isolation.
- R2: An accepted on-request sets bit2 at the accepting edge and sets bit3 one cycle later. The block then waits until `sw_ack` and `sw2_ack` are both 1.
- R3: After both power acknowledges are seen, the block clears bit4, then clears bit1, then sets bit0, one change per cycle.
- R4: Next the block drives `sram_pdn` to zero and waits until `sram_ack` is all zero. With `SRAM_ISO`=1 it then sets bit6, waits `CLK_MHZ` cycles and clears bit5.
- R5: Bus protection is released last: `prot_req` goes to 0 and the block waits for `prot_ack`=0. It then pulses `done` and raises `is_on`, with `dom_ctl` at 7'h4D when `SRAM_ISO`=1.
- R6: An accepted off-request sets `prot_req` and waits for `prot_ack`=1. With `SRAM_ISO`=1 it then sets bit5, waits `CLK_MHZ` cycles and clears bit6. It then drives `sram_pdn` to all ones and waits until `sram_ack` is all ones.
- R7: Power-down continues with: set bit1, set bit4, clear bit0, clear bit3, clear bit2, one per cycle. It then waits until both power acknowledges are 0, pulses `done`, and clears `is_on`.
- R8: Each wait lasts at most `CLK_MHZ`*`TMO_US` cycles. If a power-down wait expires, the block stops, pulses `done` and `err` together, and leaves `is_on` at 1.
- R9: If a power-up wait expires, the block undoes the steps it has completed, in reverse order, and ends in the off pattern. It then pulses `done` and `err` with `is_on` at 0. Waits that expire during this undo are passed over.
- R10: A request that arrives while `busy` is high is ignored. A request for the state already reached gives `done` in the next cycle and changes nothing else. If both requests are high at once, `req_on` wins.
- R11: `busy` is high from the cycle after an accepted request up to the `done` cycle. `done` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_on | input | 1 | Power-up request |
| req_off | input | 1 | Power-down request |
| sw_ack | input | 1 | First power switch acknowledge |
| sw2_ack | input | 1 | Second power switch acknowledge |
| sram_ack | input | SRAM_W | SRAM power-down acknowledge, one bit per bank |
| prot_ack | input | 1 | Bus protection engaged status |
| dom_ctl | output | 7 | Domain control bits |
| sram_pdn | output | SRAM_W | SRAM power-down vector |
| prot_req | output | 1 | Bus protection request, 1 = engage |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| is_on | output | 1 | Domain is powered |
| err | output | 1 | Timeout error, pulses with done |

## Verification
The bench builds the block with `CLK_MHZ`=4, `TMO_US`=6, `SRAM_W`=3 and `SRAM_ISO`=1. With these values the settle delay is four cycles and every wait times out after 24 cycles. This puts expired acknowledges within a short run: a stuck second power switch, a stuck SRAM acknowledge on the way down, and bus protection that will not release. The bench also changes the plant's acknowledge latency between runs, so each wait is exercised both when it is satisfied at once and when it is satisfied after several cycles.

// File: rtl/pd_seq.sv
module pd_seq #(
  parameter int CLK_MHZ = 100,
  parameter int TMO_US = 1000000,
  parameter int SRAM_W = 4,
  parameter bit SRAM_ISO = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              sw_ack,
  input  logic              sw2_ack,
  input  logic [SRAM_W-1:0] sram_ack,
  input  logic              prot_ack,
  output logic [6:0]        dom_ctl,
  output logic [SRAM_W-1:0] sram_pdn,
  output logic              prot_req,
  output logic              busy,
  output logic              done,
  output logic              is_on,
  output logic              err
);
  localparam int TMO_CYC = CLK_MHZ * TMO_US;
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int RSTN = 0, ISO = 1, ON1 = 2, ON2 = 3, CKDIS = 4, SCKISO = 5, SISON = 6;
  localparam logic [6:0] OFF_CTL = 7'b0110010;

  typedef enum logic [4:0] {
    IDLE, U_ON2, U_WPWR, U_CLK, U_ISO, U_RST, U_SRAM, U_WSRAM, U_SISO, U_DLY,
    U_CKISO, U_BP, U_WBP, D_WBP, D_CKISO, D_DLY, D_SISO, D_PDN, D_WSRAM,
    D_ISO, D_CLK, D_RST, D_ON2, D_ON, D_WPWR
  } st_t;

  st_t st;
  logic [TW-1:0] tmr;
  logic abort;

  wire both_on  = sw_ack & sw2_ack;
  wire both_off = ~sw_ack & ~sw2_ack;
  wire tmo      = tmr == TW'(TMO_CYC - 1);
  wire dly_end  = tmr == TW'(CLK_MHZ - 1);

  assign busy = st != IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; dom_ctl <= OFF_CTL; sram_pdn <= '1; prot_req <= 1'b1;
      done <= 1'b0; err <= 1'b0; is_on <= 1'b0; tmr <= '0; abort <= 1'b0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      tmr <= '0;
      case (st)
        IDLE: begin
          abort <= 1'b0;
          if (req_on) begin
            if (is_on) done <= 1'b1;
            else begin dom_ctl[ON1] <= 1'b1; st <= U_ON2; end
          end else if (req_off) begin
            if (!is_on) done <= 1'b1;
            else begin prot_req <= 1'b1; st <= D_WBP; end
          end
        end
        U_ON2: begin dom_ctl[ON2] <= 1'b1; st <= U_WPWR; end
        U_WPWR:
          if (both_on) st <= U_CLK;
          else if (tmo) begin abort <= 1'b1; st <= D_ISO; end
          else tmr <= tmr + 1'b1;
        U_CLK: begin dom_ctl[CKDIS] <= 1'b0; st <= U_ISO; end
        U_ISO: begin dom_ctl[ISO] <= 1'b0; st <= U_RST; end
        U_RST: begin dom_ctl[RSTN] <= 1'b1; st <= U_SRAM; end
        U_SRAM: begin sram_pdn <= '0; st <= U_WSRAM; end
        U_WSRAM:
          if (sram_ack == '0) st <= SRAM_ISO ? U_SISO : U_BP;
          else if (tmo) begin abort <= 1'b1; st <= D_PDN; end
          else tmr <= tmr + 1'b1;
        U_SISO: begin dom_ctl[SISON] <= 1'b1; st <= U_DLY; end
        U_DLY: if (dly_end) st <= U_CKISO; else tmr <= tmr + 1'b1;
        U_CKISO: begin dom_ctl[SCKISO] <= 1'b0; st <= U_BP; end
        U_BP: begin prot_req <= 1'b0; st <= U_WBP; end
        U_WBP:
          if (!prot_ack) begin st <= IDLE; done <= 1'b1; is_on <= 1'b1; end
          else if (tmo) begin abort <= 1'b1; prot_req <= 1'b1; st <= D_WBP; end
          else tmr <= tmr + 1'b1;
        D_WBP:
          if (prot_ack || (tmo && abort)) st <= SRAM_ISO ? D_CKISO : D_PDN;
          else if (tmo) begin st <= IDLE; done <= 1'b1; err <= 1'b1; end
          else tmr <= tmr + 1'b1;
        D_CKISO: begin dom_ctl[SCKISO] <= 1'b1; st <= D_DLY; end
        D_DLY: if (dly_end) st <= D_SISO; else tmr <= tmr + 1'b1;
        D_SISO: begin dom_ctl[SISON] <= 1'b0; st <= D_PDN; end
        D_PDN: begin sram_pdn <= '1; st <= D_WSRAM; end
        D_WSRAM:
          if (&sram_ack || (tmo && abort)) st <= D_ISO;
          else if (tmo) begin st <= IDLE; done <= 1'b1; err <= 1'b1; end
          else tmr <= tmr + 1'b1;
        D_ISO: begin dom_ctl[ISO] <= 1'b1; st <= D_CLK; end
        D_CLK: begin dom_ctl[CKDIS] <= 1'b1; st <= D_RST; end
        D_RST: begin dom_ctl[RSTN] <= 1'b0; st <= D_ON2; end
        D_ON2: begin dom_ctl[ON2] <= 1'b0; st <= D_ON; end
        D_ON: begin dom_ctl[ON1] <= 1'b0; st <= D_WPWR; end
        D_WPWR:
          if (both_off || (tmo && abort)) begin
            st <= IDLE; done <= 1'b1; is_on <= 1'b0; err <= abort;
          end else if (tmo) begin st <= IDLE; done <= 1'b1; err <= 1'b1; end
          else tmr <= tmr + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk #(
  parameter int SRAM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [6:0]        dom_ctl,
  input logic [SRAM_W-1:0] sram_pdn,
  input logic              prot_req,
  input logic              busy,
  input logic              done,
  input logic              is_on,
  input logic              err
);
  AST_SW2_AFTER_SW1: assert property (@(posedge clk) disable iff (!rst_n) $rose(dom_ctl[3]) |-> dom_ctl[2]); // R2
  AST_RST_LAST: assert property (@(posedge clk) disable iff (!rst_n) $rose(dom_ctl[0]) |-> !dom_ctl[1] && !dom_ctl[4] && dom_ctl[3]); // R3
  AST_PDN_CLR_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n) $fell(sram_pdn[0]) |-> dom_ctl[0]); // R4
  AST_PROT_REL_LAST: assert property (@(posedge clk) disable iff (!rst_n) $fell(prot_req) |-> sram_pdn == '0 && dom_ctl[0]); // R5
  AST_ON_PATTERN: assert property (@(posedge clk) disable iff (!rst_n) $rose(is_on) |-> dom_ctl[0] && !dom_ctl[1] && dom_ctl[2] && dom_ctl[3] && !dom_ctl[4] && !prot_req); // R5
  AST_PDN_UNDER_PROT: assert property (@(posedge clk) disable iff (!rst_n) $rose(sram_pdn[0]) |-> prot_req); // R6
  AST_SW1_DROP_LAST: assert property (@(posedge clk) disable iff (!rst_n) $fell(dom_ctl[2]) |-> !dom_ctl[3] && !dom_ctl[0] && dom_ctl[1] && dom_ctl[4]); // R7
  AST_OFF_PATTERN: assert property (@(posedge clk) disable iff (!rst_n) $fell(is_on) |-> dom_ctl[3:0] == 4'b0010 && dom_ctl[4] && &sram_pdn && prot_req); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) err |-> done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R11
endmodule

bind pd_seq pd_seq_chk #(.SRAM_W(SRAM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dom_ctl(dom_ctl), .sram_pdn(sram_pdn), .prot_req(prot_req),
  .busy(busy), .done(done), .is_on(is_on), .err(err)
);

// File: tb/sim_pd_seq.sv
module sim_pd_seq;
  localparam int CLK_MHZ = 4;
  localparam int TMO_US = 6;
  localparam int SW = 3;
  localparam bit SISO = 1'b1;
  localparam int TMO = CLK_MHZ * TMO_US;

  logic clk = 1'b0, rst_n = 1'b0, req_on = 1'b0, req_off = 1'b0;
  logic sw_ack, sw2_ack, prot_ack;
  logic [SW-1:0] sram_ack;
  logic [6:0] dom_ctl;
  logic [SW-1:0] sram_pdn;
  logic prot_req, busy, done, is_on, err;

  pd_seq #(.CLK_MHZ(CLK_MHZ), .TMO_US(TMO_US), .SRAM_W(SW), .SRAM_ISO(SISO)) u0 (
    .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off), .sw_ack(sw_ack),
    .sw2_ack(sw2_ack), .sram_ack(sram_ack), .prot_ack(prot_ack), .dom_ctl(dom_ctl),
    .sram_pdn(sram_pdn), .prot_req(prot_req), .busy(busy), .done(done), .is_on(is_on), .err(err));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;

  // plant: acknowledges follow the controls after a settable latency
  logic [7:0] a_h = '0, b_h = '0, p_h = '1;
  logic [SW-1:0] s_h [0:7];
  int da = 2, db = 3, ds = 1, dp = 2;
  bit kill_b = 0, kill_s = 0, kill_p = 0;
  assign sw_ack   = a_h[da];
  assign sw2_ack  = kill_b ? 1'b0 : b_h[db];
  assign sram_ack = kill_s ? '0 : s_h[ds];
  assign prot_ack = kill_p ? 1'b1 : p_h[dp];

  initial begin
    for (int i = 0; i < 8; i++) s_h[i] = '1;
    forever begin
      @(negedge clk);
      a_h = {a_h[6:0], dom_ctl[2]};
      b_h = {b_h[6:0], dom_ctl[3]};
      p_h = {p_h[6:0], prot_req};
      for (int i = 7; i > 0; i--) s_h[i] = s_h[i-1];
      s_h[0] = sram_pdn;
    end
  end

  // behavioural reference model
  logic [6:0] m_ctl = 7'h32;
  logic [SW-1:0] m_pdn = '1;
  logic m_bp = 1, m_busy = 0, m_done = 0, m_on = 0, m_err = 0;
  string m_tag = "R1";

  task automatic step();
    @(posedge clk);
  endtask

  task automatic m_wait(input int kind, output bit ok);
    int cnt = 0;
    forever begin
      @(posedge clk);
      case (kind)
        0: ok = sw_ack && sw2_ack;
        1: ok = sram_ack == '0;
        2: ok = !prot_ack;
        3: ok = prot_ack;
        4: ok = &sram_ack;
        default: ok = !sw_ack && !sw2_ack;
      endcase
      if (ok) return;
      if (cnt == TMO - 1) begin ok = 0; return; end
      cnt++;
    end
  endtask

  task automatic m_fail();
    m_busy = 0; m_done = 1; m_err = 1;
  endtask

  task automatic m_down(input int entry, input bit ab);
    bit ok;
    if (entry == 0) begin
      m_tag = "R6";
      m_wait(3, ok);
      if (!ok && !ab) begin m_fail(); return; end
      if (SISO) begin
        step(); m_ctl[5] = 1;
        repeat (CLK_MHZ) @(posedge clk);
        step(); m_ctl[6] = 0;
      end
    end
    if (entry <= 1) begin
      m_tag = "R6";
      step(); m_pdn = '1;
      m_wait(4, ok);
      if (!ok && !ab) begin m_fail(); return; end
    end
    m_tag = ab ? "R9" : "R7";
    step(); m_ctl[1] = 1;
    step(); m_ctl[4] = 1;
    step(); m_ctl[0] = 0;
    step(); m_ctl[3] = 0;
    step(); m_ctl[2] = 0;
    m_wait(5, ok);
    if (!ok && !ab) begin m_fail(); return; end
    m_busy = 0; m_done = 1; m_on = 0; m_err = ab;
  endtask

  task automatic m_up();
    bit ok;
    m_tag = "R2";
    m_ctl[2] = 1; m_busy = 1;
    step(); m_ctl[3] = 1;
    m_wait(0, ok);
    if (!ok) begin m_down(2, 1); return; end
    m_tag = "R3";
    step(); m_ctl[4] = 0;
    step(); m_ctl[1] = 0;
    step(); m_ctl[0] = 1;
    m_tag = "R4";
    step(); m_pdn = '0;
    m_wait(1, ok);
    if (!ok) begin m_down(1, 1); return; end
    if (SISO) begin
      step(); m_ctl[6] = 1;
      repeat (CLK_MHZ) @(posedge clk);
      step(); m_ctl[5] = 0;
    end
    m_tag = "R5";
    step(); m_bp = 0;
    m_wait(2, ok);
    if (!ok) begin m_bp = 1; m_down(0, 1); return; end
    m_busy = 0; m_done = 1; m_on = 1;
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      m_done = 0; m_err = 0; m_tag = "R10";
      if (req_on) begin
        if (m_on) m_done = 1; else m_up();
      end else if (req_off) begin
        if (!m_on) m_done = 1;
        else begin m_bp = 1; m_busy = 1; m_down(0, 0); end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      compared++;
      if (dom_ctl !== m_ctl || sram_pdn !== m_pdn || prot_req !== m_bp || busy !== m_busy ||
          done !== m_done || is_on !== m_on || err !== m_err) begin
        mismatched++;
        $display("FAIL %s cycle %0d actual ctl=%h pdn=%b prot=%b busy=%b done=%b on=%b err=%b expected ctl=%h pdn=%b prot=%b busy=%b done=%b on=%b err=%b",
                 m_tag, cycles, dom_ctl, sram_pdn, prot_req, busy, done, is_on, err,
                 m_ctl, m_pdn, m_bp, m_busy, m_done, m_on, m_err);
      end
    end
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL R11 watchdog expired actual=%0d expected<=50000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit on);
    @(negedge clk);
    if (on) req_on = 1; else req_off = 1;
    @(negedge clk);
    req_on = 0; req_off = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 600) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R11 done seen", {15'd0, done}, 16'd1);
  endtask

  task automatic chk_on(input string tag);
    chk(dom_ctl === 7'h4D && sram_pdn === '0 && !prot_req && is_on && !err, tag,
        {is_on, prot_req, 4'(sram_pdn), 3'd0, dom_ctl}, {1'b1, 1'b0, 4'd0, 3'd0, 7'h4D});
  endtask

  task automatic chk_off(input string tag, input bit e);
    chk(dom_ctl === 7'h32 && &sram_pdn && prot_req && !is_on && err === e, tag,
        {is_on, prot_req, err, 6'd0, dom_ctl}, {1'b0, 1'b1, e, 6'd0, 7'h32});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(dom_ctl === 7'h32 && &sram_pdn && prot_req && !busy && !done && !is_on && !err,
        "R1 reset state", {9'd0, dom_ctl}, 16'h0032);
    rst_n = 1;
    repeat (2) @(negedge clk);

    pulse(1); wait_done(); chk_on("R5 on after first power-up");
    repeat (3) @(negedge clk);
    pulse(1);
    chk(done && !busy && is_on && dom_ctl === 7'h4D, "R10 repeat on request", {9'd0, dom_ctl}, 16'h004D);
    repeat (2) @(negedge clk);

    pulse(0);
    repeat (3) @(negedge clk);
    pulse(1);
    wait_done(); chk_off("R7 off after power-down", 0);
    repeat (3) @(negedge clk);
    chk(!busy && !is_on, "R10 request during busy ignored", {14'd0, busy, is_on}, 16'd0);
    pulse(0);
    chk(done && !busy && !is_on, "R10 repeat off request", {14'd0, done, busy}, 16'd2);

    da = 0; db = 0; ds = 0; dp = 0;
    repeat (2) @(negedge clk);
    pulse(1); wait_done(); chk_on("R2 fast acknowledges up");
    repeat (2) @(negedge clk);
    pulse(0); wait_done(); chk_off("R6 fast acknowledges down", 0);
    da = 5; db = 7; ds = 6; dp = 4;
    repeat (2) @(negedge clk);
    pulse(1); wait_done(); chk_on("R4 slow acknowledges up");
    repeat (2) @(negedge clk);
    pulse(0); wait_done(); chk_off("R7 slow acknowledges down", 0);

    da = 2; db = 3; ds = 1; dp = 2;
    kill_b = 1;
    repeat (2) @(negedge clk);
    pulse(1); wait_done(); chk_off("R9 undo after stuck power acknowledge", 1);
    kill_b = 0;
    repeat (10) @(negedge clk);

    pulse(1); wait_done(); chk_on("R5 on after recovery");
    kill_s = 1;
    pulse(0); wait_done();
    chk(err && is_on, "R8 down timeout keeps on state", {14'd0, err, is_on}, 16'd3);
    kill_s = 0;
    repeat (10) @(negedge clk);
    pulse(0); wait_done(); chk_off("R8 retry of power-down", 0);

    kill_p = 1;
    repeat (10) @(negedge clk);
    pulse(1); wait_done(); chk_off("R9 undo after stuck bus protection", 1);
    kill_p = 0;
    repeat (10) @(negedge clk);
    pulse(1); wait_done(); chk_on("R5 final power-up");
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule